// File: doc/BRIEF.md
# Key-Sequenced Independent Watchdog

This block is a free-running, down-counting watchdog that software controls only by writing 16-bit magic values to a key register. One key arms the watchdog, another refills the counter, and a pair of keys opens and closes write access to the divider-select and load-value registers. Once armed the watchdog cannot be halted by any key; only the block's reset returns it to the idle state. When the counter runs out, a reset-request output goes high and stays high.

Values written to the divider-select and load-value registers reach the counting logic only after a fixed transfer latency, standing in for a crossing into a slower watchdog clock. While a transfer is outstanding a per-register busy flag is visible in the status register. The status register also reports whether the watchdog is armed. A revision register returns a value that tells software this armed-status bit exists.

The run side is a three-state machine. RS_IDLE goes to RS_RUN on the start key (transition "arm"). RS_RUN goes to RS_EXPIRED when the counter is found at zero (transition "bite"). RS_RUN stays in RS_RUN on the refill key (transition "feed"). RS_EXPIRED leaves only on reset. The access side is a two-state machine. LK_SHUT goes to LK_OPEN on the open key (transition "open"). LK_OPEN goes back to LK_SHUT on the close key (transition "shut"). Either state may take either key at any time.

Top module: `kwdog_top`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0, the load-value register (offset 0x08) reads 0xFFF, the divider-select register (offset 0x04) reads 0, and rst_req is 0.
- R2: The revision register at offset 0x3F4 reads 0x31. Any offset without a register reads 0.
- R3: Writing 0x5555 to the key register (offset 0x00) opens write access, and writing 0x0000 closes it. Writes to offsets 0x04 and 0x08 while access is closed change neither the read-back value nor the busy flags.
- R4: An accepted write to 0x04 sets status bit 0, and an accepted write to 0x08 sets status bit 1. Each flag stays high for exactly 3 cycles after the write edge. The counting logic uses the new value only once the flag has cleared.
- R5: Key 0xCCCC written while idle arms the watchdog. The counter loads the transferred load value, and status bit 8 reads 1 from the next cycle.
- R6: Divider code c (bits 2:0 of offset 0x04) gives a tick every 2^(c+2) cycles for c up to 6, and code 7 acts as code 6 (divide by 256). With load value L and divider D, rst_req rises L*D+1 cycles after the arm edge, so a load value of 0 expires one cycle after arming.
- R7: Key 0xAAAA while armed refills the counter from the transferred load value and restarts the divider. While idle it has no effect.
- R8: No key value stops an armed watchdog. Key values other than the four defined ones have no effect, and only bits 15:0 of a key write are compared.
- R9: After expiry, rst_req and status bit 8 stay 1 until reset, and refill keys no longer have any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | Reset request, held high after expiry |

## Verification
If the run state is corrupted, status bit 8 shows it on the very next read, and rst_req either rises at the wrong point or falls again. If the counter or the divider holds a wrong value, the edge on which rst_req rises moves. The bench therefore measures expiry to the exact cycle after arming, after feeding, and for the extreme divider codes. A wrong lock state or a transfer pipeline of the wrong length shows within one to four cycles, as a wrong read-back value or a busy flag with the wrong width. A load value used before its transfer has finished shifts expiry by thousands of cycles.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_RUN,
        RS_EXPIRED
    } run_state_t;

    typedef enum logic {
        LK_SHUT,
        LK_OPEN
    } lock_state_t;

    localparam logic [15:0] KEY_ARM  = 16'hCCCC;
    localparam logic [15:0] KEY_FEED = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN = 16'h5555;
    localparam logic [15:0] KEY_SHUT = 16'h0000;

    localparam logic [11:0] OFS_KEY  = 12'h000;
    localparam logic [11:0] OFS_DIV  = 12'h004;
    localparam logic [11:0] OFS_LOAD = 12'h008;
    localparam logic [11:0] OFS_STAT = 12'h00C;
    localparam logic [11:0] OFS_REV  = 12'h3F4;

    localparam int STAT_DIV_BUSY  = 0;
    localparam int STAT_LOAD_BUSY = 1;
    localparam int STAT_ARMED     = 8;

endpackage

// File: rtl/kwdog_ctl.sv
module kwdog_ctl
    import kwdog_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             cnt_zero,
    output run_state_t       run_state,
    output lock_state_t      lock_state,
    output logic             cnt_load,
    output logic             bite
);

    run_state_t  run_nxt;
    lock_state_t lock_nxt;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_state  <= RS_IDLE;
            lock_state <= LK_SHUT;
        end else begin
            run_state  <= run_nxt;
            lock_state <= lock_nxt;
        end
    end

    // next-state logic
    always_comb begin
        run_nxt  = run_state;
        lock_nxt = lock_state;
        unique case (run_state)
            RS_IDLE:    if (key_wr && key_val == KEY_ARM) run_nxt = RS_RUN;
            RS_RUN:     if (cnt_zero) run_nxt = RS_EXPIRED;
            RS_EXPIRED: run_nxt = RS_EXPIRED;
            default:    run_nxt = RS_IDLE;
        endcase
        unique case (lock_state)
            LK_SHUT: if (key_wr && key_val == KEY_OPEN) lock_nxt = LK_OPEN;
            LK_OPEN: if (key_wr && key_val == KEY_SHUT) lock_nxt = LK_SHUT;
            default: lock_nxt = LK_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        cnt_load = 1'b0;
        bite     = 1'b0;
        unique case (run_state)
            RS_IDLE:    cnt_load = key_wr && key_val == KEY_ARM;
            RS_RUN:     cnt_load = key_wr && key_val == KEY_FEED;
            RS_EXPIRED: bite = 1'b1;
            default:    bite = 1'b0;
        endcase
    end

endmodule

// File: rtl/kwdog_xfer.sv
module kwdog_xfer #(
    parameter int           W       = 12,
    parameter int           LAT     = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] staged,
    output logic [W-1:0] active,
    output logic         pending
);

    localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [TW-1:0] tmr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged  <= RST_VAL;
            active  <= RST_VAL;
            pending <= 1'b0;
            tmr     <= '0;
        end else if (wr) begin
            staged  <= din;
            pending <= 1'b1;
            tmr     <= TW'(LAT - 1);
        end else if (pending) begin
            if (tmr == '0) begin
                pending <= 1'b0;
                active  <= staged;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/kwdog_cnt.sv
module kwdog_cnt #(
    parameter int CNT_W  = 12,
    parameter int PS_W   = 3,
    parameter int PS_CAP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [PS_W-1:0]  ps_code,
    output logic             zero
);

    localparam int PC_W = PS_CAP + 2;

    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0]  pcnt;
    logic [PC_W-1:0]  lim;

    always_comb begin
        int sh;
        sh  = (int'(ps_code) > PS_CAP) ? PS_CAP : int'(ps_code);
        lim = PC_W'((32'd1 << (sh + 2)) - 32'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (load) begin
            cnt  <= load_val;
            pcnt <= '0;
        end else if (run && cnt != '0) begin
            if (pcnt >= lim) begin
                pcnt <= '0;
                cnt  <= cnt - 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwdog_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter int          KEY_W    = 16,
    parameter int          CNT_W    = 12,
    parameter int          PS_W     = 3,
    parameter int          PS_CAP   = 6,
    parameter int          SYNC_LAT = 3,
    parameter logic [31:0] REV      = 32'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    localparam logic [CNT_W-1:0] LOAD_RST = '1;

    run_state_t       run_state;
    lock_state_t      lock_state;
    logic             key_wr, cnt_load, cnt_zero, bite;
    logic             run_flag, unlocked;
    logic             div_wr, load_wr, ps_pend, rl_pend;
    logic [PS_W-1:0]  ps_staged, ps_active;
    logic [CNT_W-1:0] rl_staged, rl_active;

    assign key_wr   = bus_we && bus_addr == ADDR_W'(OFS_KEY);
    assign unlocked = (lock_state == LK_OPEN);
    assign div_wr   = bus_we && unlocked && bus_addr == ADDR_W'(OFS_DIV);
    assign load_wr  = bus_we && unlocked && bus_addr == ADDR_W'(OFS_LOAD);
    assign run_flag = (run_state != RS_IDLE);

    kwdog_ctl #(.KEY_W(KEY_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .key_wr(key_wr), .key_val(bus_wdata[KEY_W-1:0]),
        .cnt_zero(cnt_zero),
        .run_state(run_state), .lock_state(lock_state),
        .cnt_load(cnt_load), .bite(bite)
    );

    kwdog_xfer #(.W(PS_W), .LAT(SYNC_LAT), .RST_VAL('0)) u_ps_xfer (
        .clk(clk), .rst_n(rst_n), .wr(div_wr), .din(bus_wdata[PS_W-1:0]),
        .staged(ps_staged), .active(ps_active), .pending(ps_pend)
    );

    kwdog_xfer #(.W(CNT_W), .LAT(SYNC_LAT), .RST_VAL(LOAD_RST)) u_rl_xfer (
        .clk(clk), .rst_n(rst_n), .wr(load_wr), .din(bus_wdata[CNT_W-1:0]),
        .staged(rl_staged), .active(rl_active), .pending(rl_pend)
    );

    kwdog_cnt #(.CNT_W(CNT_W), .PS_W(PS_W), .PS_CAP(PS_CAP)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(run_state == RS_RUN), .load(cnt_load),
        .load_val(rl_active), .ps_code(ps_active),
        .zero(cnt_zero)
    );

    assign rst_req = bite;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_DIV):  bus_rdata = DATA_W'(ps_staged);
            ADDR_W'(OFS_LOAD): bus_rdata = DATA_W'(rl_staged);
            ADDR_W'(OFS_STAT): begin
                bus_rdata[STAT_DIV_BUSY]  = ps_pend;
                bus_rdata[STAT_LOAD_BUSY] = rl_pend;
                bus_rdata[STAT_ARMED]     = run_flag;
            end
            ADDR_W'(OFS_REV):  bus_rdata = DATA_W'(REV);
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rst_req,
    input logic              running,
    input logic              open,
    input logic              pend_rl
);

    // R9: the reset request never drops before reset
    p_req_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R9: a reset request only comes from an armed watchdog
    p_req_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> running);

    // R8: no key disarms the watchdog
    p_no_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R5: the arm key takes effect on the next cycle
    p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(12'h000) && bus_wdata[15:0] == 16'hCCCC && !running)
        |=> running);

    // R3: a closed load register raises no busy flag
    p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(12'h008) && !open && !pend_rl) |=> !pend_rl);

    // R4: an accepted load write raises the busy flag
    p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(12'h008) && open) |=> pend_rl);

endmodule

bind kwdog_top kwdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rst_req(rst_req), .running(run_flag),
    .open(unlocked), .pend_rl(rl_pend)
);

// File: tb/kwdog_top_tb.sv
module kwdog_top_tb;

    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h00C;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    kwdog_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // behavioural reference model
    int m_run = 0, m_open = 0;
    int m_ps_stage = 0, m_ps_act = 0, m_ps_wait = 0;
    int m_rl_stage = 'hFFF, m_rl_act = 'hFFF, m_rl_wait = 0;
    int m_left = 0, m_sub = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_open = 0;
            m_ps_stage = 0; m_ps_act = 0; m_ps_wait = 0;
            m_rl_stage = 'hFFF; m_rl_act = 'hFFF; m_rl_wait = 0;
            m_left = 0; m_sub = 0;
        end else begin : upd
            bit iskey;
            int kv, d, o_rl_act, o_ps_act;
            iskey = bus_we && bus_addr == 12'h000;
            kv = int'(bus_wdata[15:0]);
            o_rl_act = m_rl_act;
            o_ps_act = m_ps_act;
            if (bus_we && bus_addr == 12'h004 && m_open == 1) begin
                m_ps_stage = int'(bus_wdata[2:0]); m_ps_wait = LAT;
            end else if (m_ps_wait > 0) begin
                if (m_ps_wait == 1) m_ps_act = m_ps_stage;
                m_ps_wait--;
            end
            if (bus_we && bus_addr == 12'h008 && m_open == 1) begin
                m_rl_stage = int'(bus_wdata[11:0]); m_rl_wait = LAT;
            end else if (m_rl_wait > 0) begin
                if (m_rl_wait == 1) m_rl_act = m_rl_stage;
                m_rl_wait--;
            end
            if (iskey && kv == 'h5555) m_open = 1;
            if (iskey && kv == 'h0000) m_open = 0;
            if (m_run == 0) begin
                if (iskey && kv == 'hCCCC) begin
                    m_run = 1; m_left = o_rl_act; m_sub = 0;
                end
            end else if (m_run == 1) begin
                if (m_left == 0) m_run = 2;
                else if (iskey && kv == 'hAAAA) begin
                    m_left = o_rl_act; m_sub = 0;
                end else begin
                    d = 4 << ((o_ps_act > 6) ? 6 : o_ps_act);
                    if (m_sub >= d - 1) begin m_sub = 0; m_left--; end
                    else m_sub++;
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        case (a)
            12'h004: return 32'(m_ps_stage);
            12'h008: return 32'(m_rl_stage);
            12'h00C: return {23'd0, m_run != 0, 6'd0, m_rl_wait > 0, m_ps_wait > 0};
            12'h3F4: return 32'h31;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk(rst_req == (m_run == 2), "R6 R9 model rst_req", 32'(rst_req), 32'(m_run == 2));
            chk(bus_rdata == model_rd(bus_addr), "R4 R5 model rdata", bus_rdata, model_rd(bus_addr));
        end
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        step(1'b0, 12'h00C, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0);
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic measure(input int exp_n, input string tag);
        int n = 0;
        do begin idle(); n++; end while (!rst_req && n < 100000);
        chk(n == exp_n, tag, 32'(n), 32'(exp_n));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 12'h00C;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(); idle();
        // R1 reset state
        rd(12'h00C, 32'h0, "R1 status");
        rd(12'h008, 32'hFFF, "R1 load value");
        rd(12'h004, 32'h0, "R1 divider");
        chk(rst_req == 1'b0, "R1 rst_req", 32'(rst_req), 32'h0);
        // R2 revision and unmapped offset
        rd(12'h3F4, 32'h31, "R2 revision");
        rd(12'h010, 32'h0, "R2 unmapped");
        // R3 writes while closed
        wr(12'h008, 32'h5);
        rd(12'h00C, 32'h0, "R3 no busy when closed");
        rd(12'h008, 32'hFFF, "R3 closed write ignored");
        // R7 feed while idle has no effect
        wr(12'h000, 32'hAAAA);
        rd(12'h00C, 32'h0, "R7 feed idle");
        // R4 busy flag width
        wr(12'h000, 32'h5555);
        wr(12'h008, 32'h5);
        rd(12'h00C, 32'h2, "R4 load busy c1");
        rd(12'h00C, 32'h2, "R4 load busy c2");
        rd(12'h00C, 32'h2, "R4 load busy c3");
        rd(12'h00C, 32'h0, "R4 load busy cleared");
        wr(12'h004, 32'h0);
        rd(12'h00C, 32'h1, "R4 divider busy");
        idle(); idle(); idle();
        rd(12'h008, 32'h5, "R3 open write taken");
        // R3 close then write
        wr(12'h000, 32'h0);
        wr(12'h008, 32'h9);
        idle(); idle(); idle(); idle();
        rd(12'h008, 32'h5, "R3 write after close ignored");
        // R5 arm, R7 feed, R8 no stop
        wr(12'h000, 32'hCCCC);
        rd(12'h00C, 32'h100, "R5 armed bit");
        repeat (8) idle();
        wr(12'h000, 32'hAAAA);
        wr(12'h000, 32'h0000);
        wr(12'h000, 32'h5555);
        wr(12'h000, 32'hFFFF1234);
        measure(19, "R7 R8 expiry after feed");
        // R9 sticky
        wr(12'h000, 32'hAAAA);
        idle(); idle(); idle();
        chk(rst_req == 1'b1, "R9 rst_req sticky", 32'(rst_req), 32'h1);
        rd(12'h00C, 32'h100, "R9 armed after expiry");
        // R6 divide by 256
        do_reset();
        wr(12'h000, 32'h5555); wr(12'h004, 32'h6); wr(12'h008, 32'h2);
        idle(); idle(); idle(); idle();
        wr(12'h000, 32'hCCCC);
        measure(514, "R6 code 6");
        // R6 code 7 behaves as code 6
        do_reset();
        wr(12'h000, 32'h5555); wr(12'h004, 32'h7); wr(12'h008, 32'h1);
        idle(); idle(); idle(); idle();
        wr(12'h000, 32'hCCCC);
        measure(258, "R6 code 7");
        // R6 load value zero
        do_reset();
        wr(12'h000, 32'h5555); wr(12'h008, 32'h0);
        idle(); idle(); idle(); idle();
        wr(12'h000, 32'hCCCC);
        measure(2, "R6 zero load");
        // R4 arm before transfer completes uses the old value
        do_reset();
        wr(12'h000, 32'h5555); wr(12'h008, 32'h1);
        wr(12'h000, 32'hCCCC);
        measure(16382, "R4 stale load value");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule